// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over software by running a counter from a divided system clock. Once software writes a configuration byte, the counter starts. In watchdog mode, software must service the counter by writing a fixed key to the clear address. The write must land after a programmable closed part of the period has passed and before the period ends. If the deadline passes, if the key is written while the window is still closed, or if any other value is written to the clear address, the block sends the reset sequencer a one-cycle reset request. A three-bit cause register records which of these faults happened.

The block can also run as an interval timer. In that mode it pulses an interrupt once per period and ignores clear writes. Software can later switch it into watchdog mode. The first configuration that selects watchdog mode locks the configuration until the next reset, and software has no way to stop the counter after that. Two inputs can still stop counting. A low-power halt input pauses the counter. An oscillator-stop request, honoured only when its enable input is high, stops the counter for good.

Top module: `wdw_top`

## Requirements
- R1: The counter advances once every 2^PRESC_LOG2 clock cycles, and only after the first configuration write. Before that write the block raises neither irq nor rst_req.
- R2: The period field (config bits 1:0) gives 2^BASE_EXP, 2^(BASE_EXP+1) or 2^(BASE_EXP+2) count ticks for the values 0, 1 and 2. The value 3 acts as 2. In watchdog mode (config bit 4 = 0), the end of a period without service gives a one-cycle rst_req with cause bit 0 set, and the count restarts from zero.
- R3: The window field (config bits 3:2, value w) keeps the window closed while the count is below w quarters of the period. A write of key 0xAC to the clear address (wr_sel = 1) while the window is closed gives rst_req with cause bit 1 set.
- R4: A write of key 0xAC while the window is open restarts the count from zero. No reset request is raised at the old deadline.
- R5: In watchdog mode, any value other than 0xAC written to the clear address gives rst_req with cause bit 2 set, whatever the count.
- R6: In interval mode (config bit 4 = 1), irq pulses for one cycle at the end of every period. rst_req stays low, and clear writes have no effect.
- R7: Configuration writes (wr_sel = 0) are accepted while the block is unconfigured or in interval mode. The first accepted watchdog configuration locks the register. Later configuration writes change nothing and set the sticky flag cfg_err.
- R8: A cause bit stays set until a cycle with cause_rd high clears the register. A fault in that same cycle still sets its bit.
- R9: While halt_in is high, counting stops. With config bit 5 = 1, counting resumes from the held value. With bit 5 = 0, the count is held at zero and restarts from zero after release.
- R10: kill_req together with osc_stop_en stops the block until reset: no irq, no rst_req, and clear writes are ignored. Without osc_stop_en, kill_req has no effect.
- R11: After reset, irq, rst_req, cause and cfg_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 clear |
| wr_data | input | 8 | Write data: configuration byte or clear key |
| halt_in | input | 1 | Low-power halt, pauses counting |
| kill_req | input | 1 | Oscillator-stop request |
| osc_stop_en | input | 1 | Enables acceptance of kill_req |
| cause_rd | input | 1 | Read strobe that clears the cause register |
| irq | output | 1 | Interval interrupt pulse |
| rst_req | output | 1 | One-cycle reset request |
| cause | output | 3 | Fault cause: bit 0 overflow, bit 1 early clear, bit 2 bad key |
| cfg_err | output | 1 | Sticky flag for a write to the locked configuration |

## Verification
All results are registered once. A configuration write sampled at edge W with period P gives its first overflow request or interrupt at edge W + 2^PRESC_LOG2 * P. A faulty or valid clear sampled at edge C shows its rst_req and cause in the cycle after C, and a valid clear moves the next deadline to C + 2^PRESC_LOG2 * P. A halt held for H sampled edges shifts the deadline by H. For every stimulus, the driver computes the edge number at which each irq or rst_req pulse is due and queues it. The monitor samples on falling edges against a cycle counter and flags a pulse that comes early, comes late, is missing, or was never queued.

// File: rtl/wdw_pkg.sv
// Shared types for the windowed watchdog.
// Assumes: the configuration byte uses bits 5:0; bits 7:6 of a configuration write are dropped.
package wdw_pkg;

    // Service key that software must write to the clear address
    localparam logic [7:0] CLR_KEY = 8'hAC;

    // Configuration layout; the field positions are decoded by the control logic
    typedef struct packed {
        logic       resume;    // bit 5: 1 = keep count across halt, 0 = restart from zero
        logic       interval;  // bit 4: 1 = interval timer, 0 = watchdog
        logic [1:0] win;       // bits 3:2: closed quarters of the period
        logic [1:0] per;       // bits 1:0: period exponent offset
    } wdw_cfg_t;

endpackage

// File: rtl/wdw_prescaler.sv
// Divides the system clock down to count-clock ticks.
// Assumes: PRESC_LOG2 >= 1; clr wins over en.
module wdw_prescaler #(
    parameter int PRESC_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    logic [PRESC_LOG2-1:0] div_q;

    // One tick on the last cycle of each divide period
    assign tick = en && (div_q == {PRESC_LOG2{1'b1}});

    // Free-running divider, cleared on restart and frozen when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (clr)   div_q <= '0;
        else if (en)    div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdw_counter.sv
// Counts ticks up to the selected period and reports the closed-window state.
// Assumes: BASE_EXP >= 2 so a quarter period is a whole number of ticks.
module wdw_counter #(
    parameter int BASE_EXP = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] per,
    input  logic [1:0] win,
    output logic       expire,
    output logic       closed
);
    localparam int CW = BASE_EXP + 3;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic [CW-1:0] quarter;
    logic [CW-1:0] lim;
    logic [1:0]    per_eff;

    // Decode period end and window limit from the fields
    always_comb begin
        per_eff = (per == 2'd3) ? 2'd2 : per;
        last    = (CW'(1) << (BASE_EXP + int'(per_eff))) - CW'(1);
        quarter = CW'(1) << (BASE_EXP - 2 + int'(per_eff));
        case (win)
            2'd0:    lim = '0;
            2'd1:    lim = quarter;
            2'd2:    lim = quarter << 1;
            default: lim = quarter + (quarter << 1);
        endcase
    end

    assign expire = tick && (cnt_q == last);
    assign closed = (cnt_q < lim);

    // Tick counter that wraps to zero at the period end
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (tick)    cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdw_ctrl.sv
// Holds configuration, lock and stop state; detects faults and drives the outputs.
// Assumes: expire and closed come from the counter in the same cycle.
module wdw_ctrl
    import wdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       halt_in,
    input  logic       kill_req,
    input  logic       osc_stop_en,
    input  logic       cause_rd,
    input  logic       expire,
    input  logic       closed,
    output wdw_cfg_t   cfg_q,
    output logic       locked_q,
    output logic       dead_q,
    output logic       cnt_clr,
    output logic       cnt_en,
    output logic       irq,
    output logic       rst_req,
    output logic [2:0] cause,
    output logic       cfg_err
);
    logic run_q;
    logic active, wd_mode, cfg_we, clr_we, cfg_ok;
    logic key_bad, win_bad, good_clr, ovf, ival, fault;

    // Decode writes and classify faults for this cycle
    always_comb begin
        active   = run_q && !dead_q;
        wd_mode  = active && !cfg_q.interval;
        cfg_we   = wr_en && !wr_sel;
        clr_we   = wr_en && wr_sel;
        cfg_ok   = cfg_we && !locked_q;
        key_bad  = clr_we && wd_mode && (wr_data != CLR_KEY);
        win_bad  = clr_we && wd_mode && (wr_data == CLR_KEY) && closed;
        good_clr = clr_we && wd_mode && (wr_data == CLR_KEY) && !closed;
        ovf      = expire && wd_mode;
        ival     = expire && active && cfg_q.interval;
        fault    = key_bad || win_bad || ovf;
        cnt_en   = active && !halt_in;
        cnt_clr  = !active || cfg_ok || good_clr || fault
                 || (halt_in && !cfg_q.resume);
    end

    // Configuration register, run state and one-time lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            run_q    <= 1'b0;
            locked_q <= 1'b0;
        end else if (cfg_ok) begin
            cfg_q    <= wdw_cfg_t'(wr_data[5:0]);
            run_q    <= 1'b1;
            locked_q <= !wr_data[4];
        end
    end

    // Permanent stop after an enabled oscillator-stop request
    always_ff @(posedge clk) begin
        if (!rst_n)                         dead_q <= 1'b0;
        else if (kill_req && osc_stop_en)   dead_q <= 1'b1;
    end

    // Sticky flag for writes to a locked configuration
    always_ff @(posedge clk) begin
        if (!rst_n)                     cfg_err <= 1'b0;
        else if (cfg_we && locked_q)    cfg_err <= 1'b1;
    end

    // Registered pulses and the read-to-clear cause register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
            cause   <= '0;
        end else begin
            rst_req <= fault;
            irq     <= ival;
            cause   <= (cause_rd ? 3'b000 : cause) | {key_bad, win_bad, ovf};
        end
    end
endmodule

// File: rtl/wdw_top.sv
// Windowed watchdog with interval mode, configuration lock and halt handling.
// Assumes: rst_n is synchronous and driven by the reset sequencer that consumes rst_req.
module wdw_top
    import wdw_pkg::*;
#(
    parameter int BASE_EXP   = 15,
    parameter int PRESC_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       halt_in,
    input  logic       kill_req,
    input  logic       osc_stop_en,
    input  logic       cause_rd,
    output logic       irq,
    output logic       rst_req,
    output logic [2:0] cause,
    output logic       cfg_err
);
    wdw_cfg_t cfg_q;
    logic     locked_q, dead_q;
    logic     cnt_clr, cnt_en, tick, expire, closed;

    wdw_prescaler #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .tick(tick)
    );

    wdw_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
        .per(cfg_q.per), .win(cfg_q.win), .expire(expire), .closed(closed)
    );

    wdw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .halt_in(halt_in), .kill_req(kill_req), .osc_stop_en(osc_stop_en),
        .cause_rd(cause_rd), .expire(expire), .closed(closed),
        .cfg_q(cfg_q), .locked_q(locked_q), .dead_q(dead_q),
        .cnt_clr(cnt_clr), .cnt_en(cnt_en), .irq(irq), .rst_req(rst_req),
        .cause(cause), .cfg_err(cfg_err)
    );
endmodule

// File: rtl/wdw_checker.sv
// Temporal properties of the watchdog, bound onto the top module.
// Assumes: cfg is the 6-bit configuration register as stored.
module wdw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       rst_req,
    input logic [2:0] cause,
    input logic       cause_rd,
    input logic       cfg_err,
    input logic       locked,
    input logic       dead,
    input logic [5:0] cfg
);
    a_r7_cfg_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r7_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg));

    a_r8_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_rd |=> ((cause & $past(cause)) == $past(cause)));

    a_r8_cause_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cause != 3'b000));

    a_r6_irq_rst_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    a_r2_req_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> locked);

    a_r10_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> (dead && !irq && !rst_req));
endmodule

bind wdw_top wdw_checker u_wdw_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req), .cause(cause),
    .cause_rd(cause_rd), .cfg_err(cfg_err), .locked(locked_q), .dead(dead_q),
    .cfg(cfg_q)
);

// File: tb/wdw_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues each expected pulse with its due edge,
// the falling-edge monitor pops and compares.
module wdw_top_tb_top;
    localparam int B   = 4;
    localparam int PL  = 1;
    localparam int DIV = 2;
    localparam int P0  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic halt_in = 1'b0, kill_req = 1'b0, osc_stop_en = 1'b0, cause_rd = 1'b0;
    logic irq, rst_req, cfg_err;
    logic [2:0] cause;

    wdw_top #(.BASE_EXP(B), .PRESC_LOG2(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .halt_in(halt_in), .kill_req(kill_req), .osc_stop_en(osc_stop_en),
        .cause_rd(cause_rd), .irq(irq), .rst_req(rst_req), .cause(cause),
        .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        bit          is_rst;
        logic [2:0]  why;
        string       req;
    } ev_t;
    ev_t sbq[$];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    function automatic logic [7:0] cfgb(bit resume, bit ival, int win, int per);
        return {2'b00, resume, ival, 2'(win), 2'(per)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(int unsigned at, bit is_rst, logic [2:0] why, string req);
        ev_t e;
        e.at = at; e.is_rst = is_rst; e.why = why; e.req = req;
        sbq.push_back(e);
    endtask

    // Monitor: compare every output pulse against the queue head
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sbq.size() > 0 && sbq[0].at < cyc) begin
                checks++; errors++;
                $display("FAIL %s missing pulse actual=none expected cyc=%0d", sbq[0].req, sbq[0].at);
                void'(sbq.pop_front());
            end
            if (irq || rst_req) begin
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL R2/R6 unexpected pulse actual cyc=%0d rst=%0b expected=none", cyc, rst_req);
                end else begin
                    ev_t e;
                    e = sbq.pop_front();
                    if (e.at != cyc || e.is_rst != rst_req || (e.is_rst && cause !== e.why)) begin
                        errors++;
                        $display("FAIL %s actual cyc=%0d rst=%0b cause=%0h expected cyc=%0d rst=%0b cause=%0h",
                                 e.req, cyc, rst_req, cause, e.at, e.is_rst, e.why);
                    end
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Write at a chosen sampling edge; returns that edge number
    task automatic wr_at(bit sel, logic [7:0] d, int unsigned target, output int unsigned at);
        @(negedge clk);
        while (cyc + 1 < target) @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; at = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        idle(2);
        while (sbq.size() > 0) begin
            checks++; errors++;
            $display("FAIL %s missing pulse actual=none expected cyc=%0d", sbq[0].req, sbq[0].at);
            void'(sbq.pop_front());
        end
        rst_n = 1'b0; halt_in = 1'b0; kill_req = 1'b0; osc_stop_en = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1; checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned w, c;
        // R11 reset state, R1 idle before configuration
        idle(3); rst_n = 1'b1; idle(1);
        chk("R11 irq", irq, 0); chk("R11 rst_req", rst_req, 0);
        chk("R11 cause", cause, 0); chk("R11 cfg_err", cfg_err, 0);
        idle(60);

        // R1/R2 overflow with period 0, then R8 hold and read-clear
        wr_at(0, cfgb(0, 0, 0, 0), 0, w);
        expect_ev(w + DIV*P0, 1, 3'b001, "R2 overflow p0");
        expect_ev(w + 2*DIV*P0, 1, 3'b001, "R2 overflow restart");
        wait_to(w + DIV*P0 + 10);
        chk("R8 cause held", cause, 3'b001);
        @(negedge clk); cause_rd = 1'b1; @(negedge clk); cause_rd = 1'b0;
        chk("R8 cause cleared", cause, 3'b000);
        wait_to(w + 2*DIV*P0 + 4);
        do_reset();

        // R2 period 1 and period 3 acting as 2
        wr_at(0, cfgb(0, 0, 0, 1), 0, w);
        expect_ev(w + DIV*2*P0, 1, 3'b001, "R2 overflow p1");
        wait_to(w + DIV*2*P0 + 4);
        do_reset();
        wr_at(0, cfgb(0, 0, 0, 3), 0, w);
        expect_ev(w + DIV*4*P0, 1, 3'b001, "R2 overflow p3");
        wait_to(w + DIV*4*P0 + 4);
        do_reset();

        // R3 early clear with 50% window (count 4 < 8)
        wr_at(0, cfgb(0, 0, 2, 0), 0, w);
        wr_at(1, 8'hAC, w + 10, c);
        expect_ev(c, 1, 3'b010, "R3 early clear");
        wait_to(c + 4);
        do_reset();

        // R3 boundary with 75% window: count 11 < 12 still closed
        wr_at(0, cfgb(0, 0, 3, 0), 0, w);
        wr_at(1, 8'hAC, w + 24, c);
        expect_ev(c, 1, 3'b010, "R3 closed boundary");
        wait_to(c + 4);
        do_reset();

        // R4 first open count (8 of 50%) restarts the deadline
        wr_at(0, cfgb(0, 0, 2, 0), 0, w);
        wr_at(1, 8'hAC, w + 17, c);
        expect_ev(c + DIV*P0, 1, 3'b001, "R4 deadline moved");
        wait_to(c + DIV*P0 + 4);
        chk("R4 cause only overflow", cause, 3'b001);
        do_reset();

        // R5 wrong key
        wr_at(0, cfgb(0, 0, 0, 0), 0, w);
        wr_at(1, 8'h55, w + 6, c);
        expect_ev(c, 1, 3'b100, "R5 bad key");
        wait_to(c + 4);
        do_reset();

        // R6 interval mode, R7 switch to watchdog and lock
        wr_at(0, cfgb(0, 1, 0, 0), 0, w);
        expect_ev(w + DIV*P0, 0, 3'b000, "R6 irq 1");
        expect_ev(w + 2*DIV*P0, 0, 3'b000, "R6 irq 2");
        expect_ev(w + 3*DIV*P0, 0, 3'b000, "R6 irq 3");
        wr_at(1, 8'h55, w + 40, c);
        idle(3);
        chk("R6 clear ignored cause", cause, 3'b000);
        wr_at(0, cfgb(0, 0, 0, 1), w + 100, c);
        expect_ev(c + DIV*2*P0, 1, 3'b001, "R7 watchdog after interval");
        idle(1);
        chk("R7 no err on first watchdog cfg", cfg_err, 0);
        wr_at(0, cfgb(0, 1, 0, 0), c + 10, w);
        idle(1);
        chk("R7 cfg_err set", cfg_err, 1);
        wait_to(c + DIV*2*P0 + 4);
        chk("R7 cfg_err sticky", cfg_err, 1);
        do_reset();

        // R9 halt with resume: deadline shifts by 20 edges
        wr_at(0, cfgb(1, 0, 0, 0), 0, w);
        wait_to(w + 9); halt_in = 1'b1;
        wait_to(w + 29); halt_in = 1'b0;
        expect_ev(w + DIV*P0 + 20, 1, 3'b001, "R9 resume");
        wait_to(w + DIV*P0 + 24);
        do_reset();

        // R9 halt with restart: count starts over after the last halted edge
        wr_at(0, cfgb(0, 0, 0, 0), 0, w);
        wait_to(w + 9); halt_in = 1'b1;
        wait_to(w + 29); halt_in = 1'b0;
        expect_ev(w + 29 + DIV*P0, 1, 3'b001, "R9 restart");
        wait_to(w + 29 + DIV*P0 + 4);
        do_reset();

        // R10 enabled oscillator stop is permanent
        wr_at(0, cfgb(0, 0, 0, 0), 0, w);
        wait_to(w + 5); kill_req = 1'b1; osc_stop_en = 1'b1;
        idle(1); kill_req = 1'b0; osc_stop_en = 1'b0;
        wr_at(1, 8'h55, w + 20, c);
        wait_to(w + 4*DIV*P0);
        chk("R10 stopped cause", cause, 3'b000);
        do_reset();

        // R10 stop request without enable is ignored
        wr_at(0, cfgb(0, 0, 0, 0), 0, w);
        wait_to(w + 5); kill_req = 1'b1;
        idle(1); kill_req = 1'b0;
        expect_ev(w + DIV*P0, 1, 3'b001, "R10 ignored stop");
        wait_to(w + DIV*P0 + 4);
        do_reset();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule